// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Completion

This block collects a parameterised number of level-sensitive interrupt lines from across a chip and turns them into one external-interrupt request for a single hardware thread. Every source owns a 3-bit priority, an enable bit and a latched pending flag. A programmable threshold masks the low-priority sources, and the request output rises whenever a pending, enabled source sits strictly above it.

Software services an interrupt in two steps, both through a word-wide register bus. It first reads the claim register. The read returns the ID of the most urgent eligible source and clears that source's pending flag in the same cycle. When the handler is done, software writes the same ID back to that register to complete it. Between the claim and the completion the source is held in service, and its line cannot set it pending again. After completion, a line that is still high raises the pending flag once more, so handlers can chain from one interrupt to the next.

Top module: `irq_hub`

## Requirements
- R1: After reset the request output is low, every priority, enable bit and the threshold read zero, and a claim read returns 0.
- R2: The priority of source `i` (1..N) is the word at byte offset 4*i. Only bits [2:0] are stored, and bits [31:3] read as zero.
- R3: Pending flags are read-only words at byte offset 0x1000 + 4*w. Source k shows at word k/32, bit k%32. Bus writes to them have no effect, and bit 0 of word 0 reads zero.
- R4: Enable bits use the same packing at byte offset 0x2000. Bit 0 of word 0 and bits for IDs above N read zero.
- R5: `ext_irq` is high exactly when some source is pending, enabled and has a priority strictly greater than the threshold.
- R6: A read of byte offset 0x200004 returns the ID of the highest-priority eligible source. Among equal priorities the lowest ID wins, and the read returns 0 when no source is eligible.
- R7: A claim read clears the pending flag of the returned source.
- R8: A claimed source stays not pending while its line is high until a completion write of its ID arrives. After that write a still-high line sets it pending again.
- R9: A completion write of an ID that is not in service changes no pending flag.
- R10: A source with priority 0 never raises `ext_irq` and is never returned by a claim, even when its threshold is 0.
- R11: The threshold sits at byte offset 0x200000. It stores bits [2:0], and the rest read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | NSRC+1 | Level of source i on bit i; bit 0 is unused |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| ext_irq | output | 1 | External-interrupt request to the hart |

## Verification
Arbitration is tried with three source mixes. Two equal top priorities check that the lower ID wins. Unequal priorities sitting above a low-priority source check the ordering. A source with priority 0 left alone checks that it stays masked. Setting the threshold to the highest live priority tells a strict comparison from a non-strict one. A source whose line stays high across its claim, then across a completion write naming a different ID, then across its own completion, tells apart a working in-service hold, a completion that is wrongly accepted, and a source that is never re-armed. Writing ones to the pending, enable and priority words shows which bits are stored, which are fixed at zero and which ignore the write.

// File: rtl/irq_hub_pkg.sv
// Shared constants for the interrupt hub: register offsets and field widths.
// Assumes byte addresses with word-aligned accesses.
package irq_hub_pkg;
    localparam int PRIO_W      = 3;
    localparam int WORD_W      = 32;
    localparam int REGION_LSB  = 12;
    localparam int REG_PRIO    = 0;         // region index of priority words
    localparam int REG_PEND    = 1;         // region index of pending words
    localparam int REG_EN      = 2;         // region index of enable words
    localparam int OFF_THRESH  = 'h200000;
    localparam int OFF_CLAIM   = 'h200004;
endpackage

// File: rtl/irq_hub_gate.sv
// Per-source gateway: latches a level into a pending flag, and holds the
// source in service from claim until completion. Assumes that claim and
// completion are never given for the same ID in the same cycle.
module irq_hub_gate #(
    parameter int ID   = 1,
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            level,
    input  logic            claim_fire,
    input  logic [ID_W-1:0] claim_id,
    input  logic            done_fire,
    input  logic [ID_W-1:0] done_id,
    output logic            pend,
    output logic            busy
);
    logic claim_me;
    logic done_me;

    // Decode whether this cycle's claim or completion names this source.
    always_comb begin
        claim_me = claim_fire && (claim_id == ID_W'(ID));
        done_me  = done_fire && (done_id == ID_W'(ID)) && busy;
    end

    // Pending / in-service state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            busy <= 1'b0;
        end else if (claim_me) begin
            pend <= 1'b0;
            busy <= 1'b1;
        end else if (done_me) begin
            busy <= 1'b0;
        end else if (level && !busy) begin
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_hub_arb.sv
// Priority arbiter: picks the eligible source with the highest priority
// above the threshold; the lowest ID wins ties. Purely combinational.
module irq_hub_arb
    import irq_hub_pkg::*;
#(
    parameter int NSRC = 52,
    parameter int ID_W = 6
) (
    input  logic [NSRC:0]             pend,
    input  logic [NSRC:0]             en,
    input  logic [NSRC:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thresh,
    output logic [ID_W-1:0]           best_id,
    output logic                      req
);
    logic [PRIO_W-1:0] best_p;

    // Scan from ID 1 upward; a strict compare keeps the lowest ID on ties.
    always_comb begin
        best_p  = thresh;
        best_id = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (pend[i] && en[i] && (prio[i] > best_p)) begin
                best_p  = prio[i];
                best_id = ID_W'(i);
            end
        end
        req = (best_id != '0);
    end
endmodule

// File: rtl/irq_hub.sv
// Interrupt hub top: register bus decode, priority/enable/threshold storage,
// one gateway per source and the arbiter. Assumes single-cycle bus strobes
// and ADDR_W >= 22. Read data returns one cycle after the strobe.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 52,
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC:0]     src_level,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              ext_irq
);
    localparam int ID_W   = $clog2(NSRC + 1);
    localparam int NWORDS = (NSRC + WORD_W) / WORD_W;
    localparam int REG_HI = ADDR_W - REGION_LSB;

    logic [NSRC:0][PRIO_W-1:0] prio_q;
    logic [NSRC:0]             en_q;
    logic [PRIO_W-1:0]         thr_q;
    logic [NSRC:0]             pend_vec;
    logic [NSRC:0]             busy_vec;
    logic [ID_W-1:0]           best_id;
    logic [REG_HI-1:0]         region;
    logic [9:0]                slot;
    logic [4:0]                word;
    logic                      prio_sel, pend_sel, en_sel, thr_sel, claim_sel;
    logic                      claim_rd, claim_fire, done_fire;
    logic [31:0]               rd_next;

    // Address decode into register groups.
    always_comb begin
        region    = bus_addr[ADDR_W-1:REGION_LSB];
        slot      = bus_addr[11:2];
        word      = bus_addr[6:2];
        prio_sel  = (region == REG_HI'(REG_PRIO));
        pend_sel  = (region == REG_HI'(REG_PEND)) && (bus_addr[11:7] == '0);
        en_sel    = (region == REG_HI'(REG_EN)) && (bus_addr[11:7] == '0);
        thr_sel   = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_THRESH >> 2));
        claim_sel = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_CLAIM >> 2));
        claim_rd   = bus_sel && !bus_wr && claim_sel;
        claim_fire = claim_rd && (best_id != '0);
        done_fire  = bus_sel && bus_wr && claim_sel
                     && (bus_wdata[31:ID_W] == '0);
    end

    // Writable configuration: priorities, enables and threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (bus_sel && bus_wr) begin
            for (int i = 1; i <= NSRC; i++) begin
                if (prio_sel && (slot == 10'(i)))
                    prio_q[i] <= bus_wdata[PRIO_W-1:0];
                if (en_sel && (word == 5'(i / WORD_W)))
                    en_q[i] <= bus_wdata[i % WORD_W];
            end
            if (thr_sel)
                thr_q <= bus_wdata[PRIO_W-1:0];
        end
    end

    // One gateway per source; ID 0 is tied off.
    assign pend_vec[0] = 1'b0;
    assign busy_vec[0] = 1'b0;
    for (genvar g = 1; g <= NSRC; g++) begin : g_gate
        irq_hub_gate #(.ID(g), .ID_W(ID_W)) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (src_level[g]),
            .claim_fire(claim_fire),
            .claim_id  (best_id),
            .done_fire (done_fire),
            .done_id   (bus_wdata[ID_W-1:0]),
            .pend      (pend_vec[g]),
            .busy      (busy_vec[g])
        );
    end

    irq_hub_arb #(.NSRC(NSRC), .ID_W(ID_W)) u_arb (
        .pend   (pend_vec),
        .en     (en_q),
        .prio   (prio_q),
        .thresh (thr_q),
        .best_id(best_id),
        .req    (ext_irq)
    );

    // Read data multiplexer.
    always_comb begin
        rd_next = '0;
        if (prio_sel) begin
            for (int i = 1; i <= NSRC; i++)
                if (slot == 10'(i))
                    rd_next = {{(32-PRIO_W){1'b0}}, prio_q[i]};
        end else if (pend_sel || en_sel) begin
            for (int i = 1; i <= NSRC; i++)
                if ((word == 5'(i / WORD_W)) && (word < 5'(NWORDS)))
                    rd_next[i % WORD_W] = pend_sel ? pend_vec[i] : en_q[i];
        end else if (thr_sel) begin
            rd_next = {{(32-PRIO_W){1'b0}}, thr_q};
        end else if (claim_sel) begin
            rd_next = 32'(best_id);
        end
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel && !bus_wr;
            if (bus_sel && !bus_wr)
                bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/irq_hub_checker.sv
// Protocol checker for irq_hub, attached by bind. Observes gateway state,
// arbiter outputs and the bus read path.
module irq_hub_checker #(
    parameter int NSRC = 52,
    parameter int ID_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ext_irq,
    input logic [NSRC:0]   pend_vec,
    input logic [NSRC:0]   en_vec,
    input logic [NSRC:0]   busy_vec,
    input logic            claim_rd,
    input logic            claim_fire,
    input logic [ID_W-1:0] claim_id,
    input logic [31:0]     bus_rdata
);
    // R7: the claimed source is no longer pending after the claim.
    assert_claim_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |=> !pend_vec[$past(claim_id)]);

    // R6: a claimed ID is always pending and enabled at claim time.
    assert_claim_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |-> (pend_vec[claim_id] && en_vec[claim_id]));

    // R6: a claim read with no request outstanding returns 0.
    assert_claim_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !ext_irq) |=> (bus_rdata == 32'd0));

    // R5: a request implies some pending and enabled source.
    assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> (|(pend_vec & en_vec)));

    // R3, R4: ID 0 is never pending nor enabled.
    assert_id0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vec[0] && !en_vec[0]);

    // R8: a source in service is never pending.
    for (genvar g = 1; g <= NSRC; g++) begin : g_hold
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            busy_vec[g] |-> !pend_vec[g]);
    end
endmodule

bind irq_hub irq_hub_checker #(.NSRC(NSRC), .ID_W($clog2(NSRC + 1))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_irq   (ext_irq),
    .pend_vec  (pend_vec),
    .en_vec    (en_q),
    .busy_vec  (busy_vec),
    .claim_rd  (claim_rd),
    .claim_fire(claim_fire),
    .claim_id  (best_id),
    .bus_rdata (bus_rdata)
);

// File: tb/irq_hub_test.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them against returned read data; direct checks cover ext_irq.
module irq_hub_test;
    localparam int NSRC = 52;
    localparam int AW   = 22;
    localparam logic [AW-1:0] A_PEND0 = 22'h001000;
    localparam logic [AW-1:0] A_PEND1 = 22'h001004;
    localparam logic [AW-1:0] A_EN0   = 22'h002000;
    localparam logic [AW-1:0] A_EN1   = 22'h002004;
    localparam logic [AW-1:0] A_THR   = 22'h200000;
    localparam logic [AW-1:0] A_CLM   = 22'h200004;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC:0]   src_level = '0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic            ext_irq;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    irq_hub #(.NSRC(NSRC), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ext_irq(ext_irq)
    );

    function automatic logic [AW-1:0] prio_addr(int id);
        return AW'(4 * id);
    endfunction

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read_expect(logic [AW-1:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic check_irq(logic e, string tag);
        @(negedge clk);
        checks++;
        if (ext_irq !== e) begin
            errors++;
            $display("FAIL %s: ext_irq actual=%0b expected=%0b", tag, ext_irq, e);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each returned read word with the queued expectation.
    always @(negedge clk) begin
        if (bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        check_irq(1'b0, "R1 irq after reset");
        bus_read_expect(A_CLM, 32'd0, "R1 claim after reset");
        bus_read_expect(prio_addr(3), 32'd0, "R1 priority after reset");
        bus_read_expect(A_THR, 32'd0, "R1 threshold after reset");
        bus_read_expect(A_EN0, 32'd0, "R1 enable after reset");
        // R2: priority storage width
        bus_write(prio_addr(3), 32'hFFFF_FFFF);
        bus_read_expect(prio_addr(3), 32'd7, "R2 priority low bits");
        bus_write(prio_addr(52), 32'h0000_0012);
        bus_read_expect(prio_addr(52), 32'd2, "R2 priority last source");
        // R3: pending packing, read-only
        src_level[3]  = 1'b1;
        src_level[40] = 1'b1;
        idle(2);
        bus_read_expect(A_PEND0, 32'h0000_0008, "R3 pending word0");
        bus_read_expect(A_PEND1, 32'h0000_0100, "R3 pending word1");
        bus_write(A_PEND0, 32'hFFFF_FFFF);
        bus_read_expect(A_PEND0, 32'h0000_0008, "R3 pending write ignored");
        check_irq(1'b0, "R5 no irq while disabled");
        // R4: enable packing
        bus_write(A_EN0, 32'hFFFF_FFFF);
        bus_write(A_EN1, 32'hFFFF_FFFF);
        bus_read_expect(A_EN0, 32'hFFFF_FFFE, "R4 enable bit0 fixed");
        bus_read_expect(A_EN1, 32'h001F_FFFF, "R4 enable ids above N");
        check_irq(1'b1, "R5 irq prio7 over thr0");
        // R11 / R5: threshold strict compare
        bus_write(A_THR, 32'h0000_000F);
        bus_read_expect(A_THR, 32'd7, "R11 threshold width");
        check_irq(1'b0, "R5 prio equal to threshold masked");
        bus_read_expect(A_CLM, 32'd0, "R6 claim none eligible");
        bus_write(A_THR, 32'd0);
        // R6: tie resolves to lowest ID
        bus_write(prio_addr(40), 32'd7);
        bus_read_expect(A_CLM, 32'd3, "R6 tie lowest id");
        bus_read_expect(A_PEND0, 32'd0, "R7 claim clears pending");
        idle(3);
        bus_read_expect(A_PEND0, 32'd0, "R8 no repend in service");
        check_irq(1'b1, "R5 irq for source 40");
        bus_read_expect(A_CLM, 32'd40, "R6 second claim");
        check_irq(1'b0, "R5 irq drops after claims");
        bus_read_expect(A_PEND1, 32'd0, "R7 claim clears pending word1");
        // R9: completion of an ID not in service
        bus_write(prio_addr(9), 32'd1);
        src_level[9] = 1'b1;
        idle(2);
        bus_write(A_CLM, 32'd9);
        bus_read_expect(A_PEND0, 32'h0000_0200, "R9 stray completion ignored");
        // R8: completion re-arms a still-high line
        bus_write(A_CLM, 32'd3);
        idle(2);
        bus_read_expect(A_PEND0, 32'h0000_0208, "R8 repend after completion");
        // R6: ordering by priority
        bus_write(prio_addr(3), 32'd2);
        bus_read_expect(A_CLM, 32'd3, "R6 higher priority first");
        bus_read_expect(A_CLM, 32'd9, "R6 lower priority next");
        bus_read_expect(A_CLM, 32'd0, "R6 none left");
        // R10: priority 0 never interrupts
        src_level[20] = 1'b1;
        idle(2);
        bus_read_expect(A_PEND0, 32'h0010_0000, "R10 prio0 source pending");
        check_irq(1'b0, "R10 prio0 no irq");
        bus_read_expect(A_CLM, 32'd0, "R10 prio0 not claimed");
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule